// File: doc/BRIEF.md
# Enable-Framed 4096 x 1 Static Memory

This block models a 4096-word, one-bit-wide static memory whose every access is framed by an active-low chip-enable. It runs in a single system-clock domain and samples its pins on each rising edge. The first clock that sees the enable low after it was high marks the start of a cycle. On that clock the block captures the 12-bit address, and on a write it also captures the data-in bit, into internal registers. From then until the enable goes high again, the address and data pins have no effect on the cycle in progress.

A read drives the output through three phases: high-impedance, then enabled with data not yet valid, then valid. The output-enable runs one clock ahead of the data-valid flag, so a surrounding three-state pad can be driven from it. A parameter sets the access latency. Writes store the latched bit at the latched address one clock after the cycle starts, and the output stays quiet throughout. Separate data-in and data-out pins are used, each with its own latch. Stored contents survive idle periods and reset without any refresh.

Top module: `csr1_sram_top`

## Requirements
- R1: While rst is high and on the clocks that follow it, before any cycle begins, dout_oe, dout_valid and dout are all 0.
- R2: Any rising edge that samples ce_n = 1 drives dout_oe, dout_valid and dout to 0 after that edge.
- R3: The address is captured only at the edge that first samples ce_n = 0 after ce_n = 1. Later changes on addr during the cycle do not change which word is read or written.
- R4: In a read cycle (we_n = 1 at the starting edge), dout_valid rises at the LAT-th rising edge, where the starting edge counts as the first. dout_oe rises exactly one edge earlier. Both then hold while ce_n stays 0.
- R5: While dout_valid is 1, dout equals the bit stored at the captured address. While dout_valid is 0, dout is 0.
- R6: In a write cycle (we_n = 0 at the starting edge), the data-in bit sampled at the starting edge is stored at the captured address. dout_oe stays 0 for the whole cycle.
- R7: The kind of cycle is fixed at the starting edge. A later change on we_n or din inside the cycle neither writes the array nor alters the stored bit.
- R8: If ce_n is sampled 1 at the edge where dout_valid would rise, dout_valid never rises in that cycle, and the output returns to high-impedance.
- R9: Stored bits are kept across idle time and across rst.
- R10: A write completes even when ce_n is low for only a single sampled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Active-low chip-enable framing each cycle |
| we_n | input | 1 | Write-enable, low selects a write at cycle start |
| addr | input | 12 | Word address, captured at cycle start |
| din | input | 1 | Write data bit, captured at cycle start |
| dout | output | 1 | Read data bit, 0 unless valid |
| dout_oe | output | 1 | Output-enable for an external three-state pad |
| dout_valid | output | 1 | Read data on dout is valid |

## Verification
Two events can meet on one edge: the enable rising to end a read, and the latency counter reaching the point where data becomes valid. The bench provokes this by raising ce_n on the clock just before valid is due. It then checks that valid never rises, that the scoreboard receives no item for that cycle, and that the output goes back to high-impedance. A second overlap is that address and data pins keep changing on the clock right after the start edge. The bench judges this by reading back the scoreboard's shadow values.

// File: rtl/csr1_pkg.sv
package csr1_pkg;

    localparam int unsigned ADDR_W_DEF = 12;
    localparam int unsigned LAT_DEF    = 2;
    localparam int unsigned CNT_W      = 8;

    typedef logic [CNT_W-1:0] phase_cnt_t;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_kind_e;

    typedef struct packed {
        cyc_kind_e  kind;
        phase_cnt_t cnt;
    } seq_state_t;

    function automatic cyc_kind_e kind_from_we(input logic we_n);
        return we_n ? CYC_READ : CYC_WRITE;
    endfunction

    function automatic phase_cnt_t step_cnt(input phase_cnt_t c, input phase_cnt_t lim);
        return (c < lim) ? c + phase_cnt_t'(1) : c;
    endfunction

endpackage

// File: rtl/csr1_ce_sense.sv
module csr1_ce_sense (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    output logic ce_fall
);
    logic ce_q;

    always_ff @(posedge clk) begin
        if (rst) ce_q <= 1'b1;
        else     ce_q <= ce_n;
    end

    assign ce_fall = ce_q & ~ce_n;

endmodule

// File: rtl/csr1_cycle_seq.sv
module csr1_cycle_seq
    import csr1_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_DEF,
    parameter int unsigned LAT    = LAT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_fall,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic [ADDR_W-1:0] addr_q,
    output logic              din_q,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic              oe,
    output logic              valid
);
    localparam phase_cnt_t VAL_AT = phase_cnt_t'(LAT);
    localparam phase_cnt_t OE_AT  = phase_cnt_t'(LAT - 1);

    seq_state_t st, st_nx;

    always_comb begin
        st_nx = st;
        if (ce_fall) begin
            st_nx.kind = kind_from_we(we_n);
            st_nx.cnt  = phase_cnt_t'(1);
        end else if (ce_n) begin
            st_nx.kind = CYC_IDLE;
            st_nx.cnt  = '0;
        end else if (st.kind != CYC_IDLE) begin
            st_nx.cnt = step_cnt(st.cnt, VAL_AT);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.kind <= CYC_IDLE;
            st.cnt  <= '0;
        end else begin
            st <= st_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            din_q  <= 1'b0;
        end else if (ce_fall) begin
            addr_q <= addr;
            if (!we_n) din_q <= din;
        end
    end

    assign wr_stb = (st.kind == CYC_WRITE) && (st.cnt == phase_cnt_t'(1));
    assign rd_stb = (st.kind == CYC_READ)  && (st.cnt == OE_AT);
    assign oe     = (st.kind == CYC_READ)  && (st.cnt >= OE_AT);
    assign valid  = (st.kind == CYC_READ)  && (st.cnt == VAL_AT);

    assert_idle_hiz_R2: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> (!oe && !valid));

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !ce_fall |=> $stable(addr_q));

    assert_oe_leads_valid_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> $past(oe));

    assert_write_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (ce_fall && !we_n) |=> !oe);

    assert_single_commit_R10: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

endmodule

// File: rtl/csr1_bit_array.sv
module csr1_bit_array
    import csr1_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_bit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_bit
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_stb) cells[wr_addr] <= wr_bit;
    end

    assign rd_bit = cells[rd_addr];

endmodule

// File: rtl/csr1_dout_stage.sv
module csr1_dout_stage (
    input  logic clk,
    input  logic rst,
    input  logic rd_stb,
    input  logic rd_bit,
    input  logic valid,
    output logic dout
);
    logic dout_q;

    always_ff @(posedge clk) begin
        if (rst)         dout_q <= 1'b0;
        else if (rd_stb) dout_q <= rd_bit;
    end

    assign dout = valid & dout_q;

endmodule

// File: rtl/csr1_sram_top.sv
module csr1_sram_top
    import csr1_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_DEF,
    parameter int unsigned LAT    = LAT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic              dout,
    output logic              dout_oe,
    output logic              dout_valid
);
    logic              ce_fall;
    logic [ADDR_W-1:0] addr_q;
    logic              din_q;
    logic              wr_stb;
    logic              rd_stb;
    logic              rd_bit;

    csr1_ce_sense u_sense (
        .clk     (clk),
        .rst     (rst),
        .ce_n    (ce_n),
        .ce_fall (ce_fall)
    );

    csr1_cycle_seq #(.ADDR_W(ADDR_W), .LAT(LAT)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .ce_fall (ce_fall),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .addr    (addr),
        .din     (din),
        .addr_q  (addr_q),
        .din_q   (din_q),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb),
        .oe      (dout_oe),
        .valid   (dout_valid)
    );

    csr1_bit_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .wr_stb  (wr_stb),
        .wr_addr (addr_q),
        .wr_bit  (din_q),
        .rd_addr (addr_q),
        .rd_bit  (rd_bit)
    );

    csr1_dout_stage u_dout (
        .clk     (clk),
        .rst     (rst),
        .rd_stb  (rd_stb),
        .rd_bit  (rd_bit),
        .valid   (dout_valid),
        .dout    (dout)
    );

    assert_load_before_valid_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(dout_valid) |-> $past(rd_stb));

    assert_abort_no_valid_R8: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> !$rose(dout_valid));

endmodule

// File: tb/csr1_sram_top_tb.sv
module csr1_sram_top_tb;
    localparam int AW  = 12;
    localparam int LAT = 2;

    logic clk = 1'b0;
    logic rst, ce_n, we_n, din;
    logic [AW-1:0] addr;
    logic dout, dout_oe, dout_valid;

    int n_chk = 0;
    int n_err = 0;
    logic model [1 << AW];
    logic exp_q [$];
    logic prev_v = 1'b0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    csr1_sram_top #(.ADDR_W(AW), .LAT(LAT)) u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .addr(addr),
        .din(din), .dout(dout), .dout_oe(dout_oe), .dout_valid(dout_valid)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act %b exp %b", req, act, exp);
        end
    endtask

    // scoreboard monitor: pops one expected bit on each rise of dout_valid (R4, R5)
    always @(negedge clk) begin
        if (rst) prev_v <= 1'b0;
        else begin
            if (dout_valid && !prev_v) begin
                if (exp_q.size() == 0) begin
                    n_chk++; n_err++;
                    $display("FAIL R8 act valid-rise exp none");
                end else chk("R5 read data", dout, exp_q.pop_front());
            end
            prev_v <= dout_valid;
        end
    end

    task automatic do_write(input logic [AW-1:0] a, input logic b, input bit short_pulse);
        @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a; din = b;
        @(negedge clk);
        chk("R6 oe quiet in write", dout_oe, 1'b0);
        addr = a ^ 12'h001; din = ~b; we_n = 1'b1;   // R3 R7: ignored
        if (short_pulse) ce_n = 1'b1;                // R10
        if (!short_pulse) begin
            @(negedge clk);
            chk("R6 oe quiet in write", dout_oe, 1'b0);
            ce_n = 1'b1;
        end
        @(negedge clk);
        model[a] = b;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input bit abort, input bit we_flip);
        @(negedge clk); ce_n = 1'b0; we_n = 1'b1; addr = a;
        if (!abort) exp_q.push_back(model[a]);
        for (int k = 0; k < LAT; k++) begin
            @(negedge clk);
            if (abort && k == LAT - 1) begin
                chk("R8 valid suppressed", dout_valid, 1'b0);
                chk("R8 oe released", dout_oe, 1'b0);
            end else begin
                chk("R4 oe phase", dout_oe, (k >= LAT - 2));
                chk("R4 valid phase", dout_valid, (k == LAT - 1));
            end
            if (k == 0) begin
                addr = ~a;                                  // R3
                if (we_flip) begin we_n = 1'b0; din = ~model[a]; end  // R7
            end
            if (abort && k == LAT - 2) ce_n = 1'b1;
        end
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        chk("R2 oe hi-z", dout_oe, 1'b0);
        chk("R2 valid low", dout_valid, 1'b0);
        chk("R5 dout zero when not valid", dout, 1'b0);
    endtask

    initial begin
        rst = 1'b1; ce_n = 1'b1; we_n = 1'b1; din = 1'b0; addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 oe reset", dout_oe, 1'b0);
        chk("R1 valid reset", dout_valid, 1'b0);
        chk("R1 dout reset", dout, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 oe after release", dout_oe, 1'b0);

        do_write(12'h000, 1'b1, 1'b0);
        do_write(12'h001, 1'b0, 1'b0);
        do_write(12'hFFF, 1'b1, 1'b0);
        do_write(12'hFFE, 1'b0, 1'b0);
        do_write(12'h5A5, 1'b1, 1'b1);   // R10 single-edge pulse
        do_write(12'hA5A, 1'b0, 1'b1);
        do_write(12'h5A4, 1'b0, 1'b0);

        do_read(12'h000, 1'b0, 1'b0);
        do_read(12'h001, 1'b0, 1'b0);
        do_read(12'hFFF, 1'b0, 1'b0);
        do_read(12'hFFE, 1'b0, 1'b0);
        do_read(12'h5A5, 1'b0, 1'b0);
        do_read(12'hA5A, 1'b0, 1'b0);

        // R8: enable rises on the edge where valid is due
        do_read(12'h5A5, 1'b1, 1'b0);
        // R7: we_n and din toggled mid-read; array must not change
        do_read(12'h000, 1'b0, 1'b1);
        do_read(12'h000, 1'b0, 1'b0);

        // overwrite then read back
        do_write(12'h000, 1'b0, 1'b0);
        do_read(12'h000, 1'b0, 1'b0);

        // R2: pins wiggle while idle, outputs stay quiet
        @(negedge clk); addr = 12'h123; we_n = 1'b0; din = 1'b1;
        @(negedge clk);
        chk("R2 idle oe", dout_oe, 1'b0);
        chk("R2 idle valid", dout_valid, 1'b0);
        we_n = 1'b1;

        // R9: contents survive reset
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 oe mid reset", dout_oe, 1'b0);
        rst = 1'b0;
        do_read(12'hFFF, 1'b0, 1'b0);
        do_read(12'h5A4, 1'b0, 1'b0);
        do_read(12'hA5A, 1'b0, 1'b0);

        repeat (2) @(negedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_err++;
            $display("FAIL R4 act %0d pending exp 0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL R4 act timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule